// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general-purpose register storage of a 32-bit processor core. Sixteen architectural registers are seen by software, but the physical storage behind some of them changes with the processor mode. The fast-interrupt mode gets a private set for registers 8 to 12. Every exception mode gets its own stack pointer (register 13) and link register (register 14). The low registers and the program counter are always shared.

The current processor mode is the low five bits of a current status register that the block holds itself. Changing mode is a write of that register. Each exception mode also owns a saved status register, accessed through one port that follows the current mode. A user-bank override input lets privileged code reach the user/system copies of banked registers, for example to save or restore another context.

There are two combinational read ports and one write port that lands on the rising clock edge. All three are addressed by architectural index and remapped by the current mode.

Top module: `bank_regfile`

## Requirements
- R1: Registers 0 to 7 name the same storage in every mode; a value written in one mode reads back unchanged in any other.
- R2: Registers 8 to 12 have a private copy used only in fast-interrupt mode (mode field 10001); every other mode reads and writes one common copy.
- R3: Registers 13 and 14 have private copies for supervisor (10011), abort (10111), undefined (11011), interrupt (10010) and fast-interrupt (10001) modes. User (10000) and system (11111) share one copy, and any other mode code banks as user.
- R4: Register 15 is one unbanked register, visible identically in every mode.
- R5: Each of the five exception modes owns a saved status register, read and written through one port addressed by the current mode. In user or system mode that port reads the current status register, and a write to it changes nothing.
- R6: While the user-bank override input is 1, register reads and writes address the user/system copies whatever the current mode.
- R7: A read of the slot being written in the same cycle returns the old value; the new value is visible after the clock edge.
- R8: Synchronous reset clears every register and the saved status registers to zero and sets the current status register to 0x00000013 (supervisor mode in bits 4:0).
- R9: The two read ports are independent: each returns the register its own index selects, and both return the same value when given the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| user_bank_i | input | 1 | Force register accesses onto the user/system bank |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | DATA_W | Read data, port A |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | DATA_W | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural index of the write |
| wr_data | input | DATA_W | Register write data |
| cur_stat_we | input | 1 | Current status register write enable |
| cur_stat_wdata | input | DATA_W | Current status register write data |
| cur_stat_o | output | DATA_W | Current status register |
| sav_stat_we | input | 1 | Saved status register write enable (current mode) |
| sav_stat_wdata | input | DATA_W | Saved status register write data |
| sav_stat_o | output | DATA_W | Saved status register of the current mode |
| mode_o | output | 5 | Current mode field |

## Verification
The bench writes distinct values into the same index from several modes and reads them back from others. A map that banks too much or too little then returns a wrong context's value, for example a fast-interrupt register 8 leaking into interrupt mode, or system mode not seeing the user stack pointer. An unknown mode code is driven to catch a decoder that falls into some exception bank instead of the user bank. The saved-status port is exercised in user mode, where a design that stores the write would corrupt a slot later seen from supervisor mode. Same-cycle read and write of one slot is checked on both sides of the edge, to catch a bypass path that returns the new value early.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int IDX_W   = 4;
  localparam int MODE_W  = 5;
  localparam int BANK_W  = 3;
  localparam int NSLOT   = 31;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int NEXC    = 5;

  // mode field codes
  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  // bank numbers; 0 is the user/system bank
  localparam logic [BANK_W-1:0] B_USR = 3'd0;
  localparam logic [BANK_W-1:0] B_SVC = 3'd1;
  localparam logic [BANK_W-1:0] B_ABT = 3'd2;
  localparam logic [BANK_W-1:0] B_UND = 3'd3;
  localparam logic [BANK_W-1:0] B_IRQ = 3'd4;
  localparam logic [BANK_W-1:0] B_FIQ = 3'd5;

  // physical layout: 0..12 shared/common, 13..17 fast-irq r8..r12,
  // 18..29 stack/link pairs per bank, 30 program counter
  localparam int FIQ_OFS  = 5;
  localparam int SP_BASE  = 18;
  localparam int PC_SLOT  = 30;
  localparam logic [IDX_W-1:0] IDX_HI  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_SP  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_PC  = 4'd15;

  function automatic logic [BANK_W-1:0] bank_of(input logic [MODE_W-1:0] m);
    case (m)
      M_SVC:   return B_SVC;
      M_ABT:   return B_ABT;
      M_UND:   return B_UND;
      M_IRQ:   return B_IRQ;
      M_FIQ:   return B_FIQ;
      default: return B_USR;
    endcase
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [SLOT_W-1:0] slot_o
);
  always_comb begin
    if (idx_i < IDX_HI)
      slot_o = SLOT_W'(idx_i);
    else if (idx_i < IDX_SP)
      slot_o = (bank_i == B_FIQ) ? SLOT_W'(idx_i) + SLOT_W'(FIQ_OFS) : SLOT_W'(idx_i);
    else if (idx_i < IDX_PC)
      slot_o = SLOT_W'(SP_BASE) + SLOT_W'({bank_i, 1'b0}) + SLOT_W'(idx_i - IDX_SP);
    else
      slot_o = SLOT_W'(PC_SLOT);
  end
endmodule

// File: rtl/bank_store.sv
module bank_store
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] ra_slot,
  input  logic [SLOT_W-1:0] rb_slot,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [SLOT_W-1:0] w_slot,
  input  logic [DATA_W-1:0] w_data
);
  logic [DATA_W-1:0] mem [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NSLOT; k++) mem[k] <= '0;
    end else if (we) begin
      mem[w_slot] <= w_data;
    end
  end

  assign ra_data = mem[ra_slot];
  assign rb_data = mem[rb_slot];
endmodule

// File: rtl/bank_status.sv
module bank_status
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cur_we,
  input  logic [DATA_W-1:0] cur_wd,
  input  logic              sav_we,
  input  logic [DATA_W-1:0] sav_wd,
  output logic [DATA_W-1:0] cur_q,
  output logic [DATA_W-1:0] sav_q,
  output logic [BANK_W-1:0] bank_o
);
  localparam logic [DATA_W-1:0] CUR_RST = DATA_W'(M_SVC);

  logic [DATA_W-1:0] cur_r;
  logic [DATA_W-1:0] sav_r [NEXC];
  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] sidx;

  assign bank = bank_of(cur_r[MODE_W-1:0]);
  assign sidx = bank - 3'd1;

  always_ff @(posedge clk) begin
    if (rst) cur_r <= CUR_RST;
    else if (cur_we) cur_r <= cur_wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NEXC; k++) sav_r[k] <= '0;
    end else if (sav_we && bank != B_USR) begin
      sav_r[sidx] <= sav_wd;
    end
  end

  assign cur_q  = cur_r;
  assign sav_q  = (bank == B_USR) ? cur_r : sav_r[sidx];
  assign bank_o = bank;
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              user_bank_i,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cur_stat_we,
  input  logic [DATA_W-1:0] cur_stat_wdata,
  output logic [DATA_W-1:0] cur_stat_o,
  input  logic              sav_stat_we,
  input  logic [DATA_W-1:0] sav_stat_wdata,
  output logic [DATA_W-1:0] sav_stat_o,
  output logic [4:0]        mode_o
);
  localparam int NPORT = 3;   // read A, read B, write

  logic [BANK_W-1:0] cur_bank;
  logic [BANK_W-1:0] reg_bank;
  logic [IDX_W-1:0]  port_idx  [NPORT];
  logic [SLOT_W-1:0] port_slot [NPORT];

  bank_status #(.DATA_W(DATA_W)) u_status (
    .clk    (clk),
    .rst    (rst),
    .cur_we (cur_stat_we),
    .cur_wd (cur_stat_wdata),
    .sav_we (sav_stat_we),
    .sav_wd (sav_stat_wdata),
    .cur_q  (cur_stat_o),
    .sav_q  (sav_stat_o),
    .bank_o (cur_bank)
  );

  assign reg_bank = user_bank_i ? B_USR : cur_bank;
  assign mode_o   = cur_stat_o[MODE_W-1:0];

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bank_map u_map (
      .idx_i  (port_idx[p]),
      .bank_i (reg_bank),
      .slot_o (port_slot[p])
    );
  end

  bank_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .ra_slot (port_slot[0]),
    .rb_slot (port_slot[1]),
    .ra_data (rd_a_data),
    .rb_data (rd_b_data),
    .we      (wr_en),
    .w_slot  (port_slot[2]),
    .w_data  (wr_data)
  );
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              user_bank_i,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              cur_stat_we,
  input logic [DATA_W-1:0] cur_stat_wdata,
  input logic [DATA_W-1:0] cur_stat_o,
  input logic              sav_stat_we,
  input logic [DATA_W-1:0] sav_stat_wdata,
  input logic [DATA_W-1:0] sav_stat_o,
  input logic [4:0]        mode_o
);
  // R8: leaving reset lands in supervisor mode with the rest of status clear
  p_reset_mode_r8: assert property (@(posedge clk)
    rst |=> (cur_stat_o == DATA_W'(5'b10011)));

  // R5: user/system mode shows the current status on the saved port
  p_sav_user_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 5'b10000 || mode_o == 5'b11111) |-> (sav_stat_o == cur_stat_o));

  // R5: current status changes only when written
  p_cur_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cur_stat_we |=> $stable(cur_stat_o));

  // R9: same index on both ports gives the same data
  p_ports_agree_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

  // R4: program counter is readable through both ports identically
  p_pc_single_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == 4'd15 && rd_b_idx == 4'd15) |-> (rd_a_data == rd_b_data));

  // R7: a write is visible at the same index after the edge, context unchanged
  p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(cur_stat_we) &&
     $past(wr_idx) == rd_a_idx && $past(user_bank_i) == user_bank_i)
    |-> (rd_a_data == $past(wr_data)));
endmodule

bind bank_regfile bank_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_bank_regfile.sv
module tb_bank_regfile;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          user_bank_i = 1'b0;
  logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0, cur_stat_we = 1'b0, sav_stat_we = 1'b0;
  logic [DW-1:0] cur_stat_wdata = '0, sav_stat_wdata = '0;
  logic [DW-1:0] cur_stat_o, sav_stat_o;
  logic [4:0]    mode_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  bank_regfile #(.DATA_W(DW)) dut (.*);

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b10100;
  localparam logic [1:0] OP_MODE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [4:0]  mode;
    logic [3:0]  idx;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{OP_MODE, 4'd0, USR, 4'd0,  32'h0},
    '{OP_WR,   4'd0, USR, 4'd0,  32'hA000_0000},
    '{OP_WR,   4'd0, USR, 4'd8,  32'hA000_0008},
    '{OP_WR,   4'd0, USR, 4'd13, 32'hA000_000D},
    '{OP_WR,   4'd0, USR, 4'd14, 32'hA000_000E},
    '{OP_WR,   4'd0, USR, 4'd15, 32'hA000_000F},
    '{OP_MODE, 4'd0, FIQ, 4'd0,  32'h0},
    '{OP_RD,   4'd1, FIQ, 4'd0,  32'hA000_0000},   // R1
    '{OP_RD,   4'd2, FIQ, 4'd8,  32'h0},           // R2 private copy starts clear
    '{OP_WR,   4'd0, FIQ, 4'd8,  32'hF000_0008},
    '{OP_RD,   4'd3, FIQ, 4'd13, 32'h0},           // R3
    '{OP_WR,   4'd0, FIQ, 4'd13, 32'hF000_000D},
    '{OP_MODE, 4'd0, IRQ, 4'd0,  32'h0},
    '{OP_RD,   4'd2, IRQ, 4'd8,  32'hA000_0008},   // R2 common copy
    '{OP_RD,   4'd3, IRQ, 4'd13, 32'h0},
    '{OP_WR,   4'd0, IRQ, 4'd13, 32'h1000_000D},
    '{OP_RD,   4'd4, IRQ, 4'd15, 32'hA000_000F},   // R4
    '{OP_MODE, 4'd0, SVC, 4'd0,  32'h0},
    '{OP_RD,   4'd3, SVC, 4'd13, 32'h0},
    '{OP_WR,   4'd0, SVC, 4'd13, 32'h5000_000D},
    '{OP_RD,   4'd1, SVC, 4'd0,  32'hA000_0000},   // R1
    '{OP_MODE, 4'd0, SYS, 4'd0,  32'h0},
    '{OP_RD,   4'd3, SYS, 4'd13, 32'hA000_000D},   // R3 system shares user
    '{OP_RD,   4'd2, SYS, 4'd8,  32'hA000_0008},
    '{OP_MODE, 4'd0, BAD, 4'd0,  32'h0},
    '{OP_RD,   4'd3, BAD, 4'd13, 32'hA000_000D},   // R3 unknown code -> user
    '{OP_MODE, 4'd0, FIQ, 4'd0,  32'h0},
    '{OP_RD,   4'd2, FIQ, 4'd8,  32'hF000_0008},
    '{OP_RD,   4'd3, FIQ, 4'd13, 32'hF000_000D},
    '{OP_MODE, 4'd0, ABT, 4'd0,  32'h0},
    '{OP_WR,   4'd0, ABT, 4'd14, 32'hB000_000E},
    '{OP_MODE, 4'd0, UND, 4'd0,  32'h0},
    '{OP_RD,   4'd3, UND, 4'd14, 32'h0},
    '{OP_MODE, 4'd0, IRQ, 4'd0,  32'h0},
    '{OP_RD,   4'd3, IRQ, 4'd13, 32'h1000_000D},
    '{OP_RD,   4'd4, IRQ, 4'd15, 32'hA000_000F}    // R4
  };

  task automatic chk(input int r, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk);
    cur_stat_we = 1'b1; cur_stat_wdata = {27'd0, m};
    @(negedge clk);
    cur_stat_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_sav(input logic [DW-1:0] d);
    @(negedge clk);
    sav_stat_we = 1'b1; sav_stat_wdata = d;
    @(negedge clk);
    sav_stat_we = 1'b0;
  endtask

  task automatic rd_chk(input int r, input logic [3:0] i, input logic [DW-1:0] exp);
    rd_a_idx = i; rd_b_idx = i;
    #1;
    chk(r, rd_a_data, exp, "port A read");
    chk(r, rd_b_data, exp, "port B read");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    #1;
    chk(8, cur_stat_o, 32'h0000_0013, "status after reset");
    chk(8, {27'd0, mode_o}, {27'd0, SVC}, "mode after reset");
    chk(8, sav_stat_o, 32'h0, "saved status after reset");
    rd_chk(8, 4'd13, 32'h0);

    // table walk: R1 R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      case (VEC[v].op)
        OP_MODE: set_mode(VEC[v].mode);
        OP_WR:   wr_reg(VEC[v].idx, VEC[v].val);
        default: rd_chk(int'(VEC[v].req), VEC[v].idx, VEC[v].val);
      endcase
    end

    // R5 saved status per mode
    set_mode(SVC);
    wr_sav(32'h0000_0111);
    set_mode(IRQ);
    wr_sav(32'h0000_0222);
    #1 chk(5, sav_stat_o, 32'h0000_0222, "irq saved status");
    set_mode(SVC);
    #1 chk(5, sav_stat_o, 32'h0000_0111, "svc saved status");
    set_mode(USR);
    wr_sav(32'h0000_0999);
    #1 chk(5, sav_stat_o, 32'h0000_0010, "user saved port shows current");
    set_mode(SVC);
    #1 chk(5, sav_stat_o, 32'h0000_0111, "user write ignored");
    set_mode(IRQ);
    #1 chk(5, sav_stat_o, 32'h0000_0222, "irq slot untouched");

    // R6 user-bank override
    set_mode(FIQ);
    user_bank_i = 1'b1;
    rd_chk(6, 4'd8,  32'hA000_0008);
    rd_chk(6, 4'd13, 32'hA000_000D);
    wr_reg(4'd13, 32'h0000_0077);
    user_bank_i = 1'b0;
    rd_chk(6, 4'd13, 32'hF000_000D);
    set_mode(USR);
    rd_chk(6, 4'd13, 32'h0000_0077);

    // R7 read during write
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h0000_0033; rd_a_idx = 4'd3;
    #1 chk(7, rd_a_data, 32'h0, "old value before edge");
    @(posedge clk);
    #1 chk(7, rd_a_data, 32'h0000_0033, "new value after edge");
    @(negedge clk);
    wr_en = 1'b0;

    // R9 independent ports
    rd_a_idx = 4'd0; rd_b_idx = 4'd15;
    #1;
    chk(9, rd_a_data, 32'hA000_0000, "port A r0");
    chk(9, rd_b_data, 32'hA000_000F, "port B r15");

    // R8 reset again clears storage
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk(8, cur_stat_o, 32'h0000_0013, "status after second reset");
    rd_chk(8, 4'd0, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule